// File: doc/BRIEF.md
# Multicore Reset Controller Register Block

This block is the register-mapped control point for resetting and powering a cluster of four processor cores. Software writes a control word that holds one enable bit per secondary core (cores 1 to 3) and one reset-request bit per core (cores 0 to 3). The block compares each write with the stored word. For every bit that changed, it raises a request on that core's own request channel: start, stop or reset. A start request carries an entry address and an argument taken from a fixed pair of general-purpose registers.

Each core channel is a valid/ready handshake. The request is held until the core side accepts it. After a reset or power-state action, the core's reset bit stays in the control word until that core returns a one-cycle completion pulse, and the block then clears the bit. The two peripheral software-reset bits have no handshake and read back as 0 at once. The register window is 4 KB of 32-bit aligned words. Words past the last implemented register read as 0 and ignore writes.

Top module: `mcore_rst_ctl`

## Requirements
- R1: After reset the control word (index 0) reads 0x521, the reset status word (index 2) reads 0x1, the interrupt mask word (index 4) reads 0x1F, every other register reads 0, and no core request is valid.
- R2: The word index is bus_addr shifted right by two. Index 0 is control, 1 and 5 are boot mode, 2 is reset status, 3 is interrupt status, 4 is interrupt mask, and 6 to 15 are general-purpose registers GP1 to GP10. Every register except control reads back exactly what was last written. Read data appears on bus_rdata in the cycle after the read access and holds until the next read.
- R3: An access whose address has bus_addr[1:0] not equal to 0, or whose word index is 16 or more, reads as 0 and changes no register.
- R4: A control write that equals the stored control word raises no core request.
- R5: When the enable bit of core c (c = 1..3, bit 21+c) changes, core c gets a request. A 0-to-1 change gives kind START (2'b01) with entry = GP(2c+1) (index 6+2c) and argument = GP(2c+2) (index 7+2c), using their values before the write. A 1-to-0 change gives kind STOP (2'b10).
- R6: When the reset bit of core c (c = 0..3, bit 13+c) changes, core c gets a RESET request (kind 2'b11). If core c's enable bit changes in the same write, only the R5 request is issued for that core.
- R7: A valid request keeps its kind, entry and argument stable while ready is low. Valid falls in the cycle after a cycle with valid and ready both high, unless a new request is issued in that cycle.
- R8: After a request is issued to core c, core c's reset bit (bit 13+c) is cleared on the clock edge that samples a core_done[c] pulse. A done pulse on a core with no outstanding action does not change any register.
- R9: Control bits 3 and 12 (peripheral software resets) always read 0, even right after a write of 1.
- R10: All other control bits are stored as written. Each core's request is decided independently in the same write cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Register access strobe, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address within the 4 KB window |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| core_req_valid | output | NCORE | Per-core request valid |
| core_req_kind | output | 2*NCORE | Per-core request kind, 2 bits per core: 01 start, 10 stop, 11 reset |
| core_req_entry | output | DATA_W*NCORE | Per-core entry address for start |
| core_req_arg | output | DATA_W*NCORE | Per-core argument for start |
| core_req_ready | input | NCORE | Per-core request accept |
| core_done | input | NCORE | Per-core one-cycle completion pulse |

## Verification
The bench targets a write that changes a core's enable bit and reset bit together. A design that ignored the masking would issue a RESET, or would replace the START, on that core. It also targets done pulses sent to cores with no outstanding action. A design that cleared reset bits unconditionally would drop another core's pending bit. Misaligned and past-the-end accesses are aimed at word 6 and at words past 15, which catches a decoder that truncates the index or ignores the low address bits. Random control writes toggle enable, reset and peripheral bits against a bench model that also checks the start entry and argument. This exposes a wrong register pair, or values sampled after the write instead of before it.

// File: rtl/rst_ctl_pkg.sv
package rst_ctl_pkg;

  typedef enum logic [1:0] {
    REQ_NONE  = 2'b00,
    REQ_START = 2'b01,
    REQ_STOP  = 2'b10,
    REQ_RESET = 2'b11
  } req_kind_e;

  // word indices of the register map
  localparam int IDX_CTL      = 0;
  localparam int IDX_BOOT_A   = 1;
  localparam int IDX_RSTAT    = 2;
  localparam int IDX_ISTAT    = 3;
  localparam int IDX_IMASK    = 4;
  localparam int IDX_BOOT_B   = 5;
  localparam int IDX_GP_BASE  = 6;
  localparam int NFIXED       = 6;

  // control word layout
  localparam int EN_BASE      = 22;  // core 1 enable, cores 2..3 follow
  localparam int RST_BASE     = 13;  // core 0 reset, cores 1..3 follow
  localparam int PERI_A       = 3;
  localparam int PERI_B       = 12;

  localparam logic [31:0] CTL_INIT   = 32'h0000_0521;
  localparam logic [31:0] RSTAT_INIT = 32'h0000_0001;
  localparam logic [31:0] IMASK_INIT = 32'h0000_001F;

endpackage

// File: rtl/rst_ctl_bus.sv
module rst_ctl_bus #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int NREG   = 16,
  parameter int SEL_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] rd_word,
  output logic [SEL_W-1:0]  sel_idx,
  output logic              wr_en,
  output logic [DATA_W-1:0] bus_rdata
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0]  word_idx;
  logic              hit;
  logic              rd_en;
  logic [DATA_W-1:0] rdata_d;

  assign word_idx = bus_addr[ADDR_W-1:2];
  assign hit      = (bus_addr[1:0] == 2'b00) && (word_idx < IDX_W'(NREG));
  assign sel_idx  = word_idx[SEL_W-1:0];
  assign wr_en    = bus_sel && bus_we && hit;
  assign rd_en    = bus_sel && !bus_we;

  always_comb begin
    rdata_d = hit ? rd_word : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata <= '0;
    end else if (rd_en) begin
      bus_rdata <= rdata_d;
    end
  end

  // R3: a miss never returns register content
  a_r3_miss_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && (bus_addr[1:0] != 2'b00) |=> bus_rdata == '0);

endmodule

// File: rtl/rst_ctl_regs.sv
module rst_ctl_regs
  import rst_ctl_pkg::*;
#(
  parameter int NCORE  = 4,
  parameter int NGP    = 10,
  parameter int DATA_W = 32,
  parameter int SEL_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  sel_idx,
  input  logic [DATA_W-1:0] wdata,
  input  logic [NCORE-1:0]  core_done,
  output logic [DATA_W-1:0] rd_word,
  output logic [DATA_W-1:0] ctl_q,
  output logic [NCORE-1:0]  act,
  output req_kind_e         act_kind  [NCORE],
  output logic [DATA_W-1:0] act_entry [NCORE],
  output logic [DATA_W-1:0] act_arg   [NCORE]
);
  localparam int NREG = NFIXED + NGP;

  logic [DATA_W-1:0] regs_q [NREG];
  logic [DATA_W-1:0] regs_d [NREG];
  logic [NCORE-1:0]  pend_q, pend_d;
  logic [DATA_W-1:0] chg;
  logic              wr_ctl;
  logic              upd;

  function automatic logic [DATA_W-1:0] reg_init(input int i);
    case (i)
      IDX_CTL:   reg_init = DATA_W'(CTL_INIT);
      IDX_RSTAT: reg_init = DATA_W'(RSTAT_INIT);
      IDX_IMASK: reg_init = DATA_W'(IMASK_INIT);
      default:   reg_init = '0;
    endcase
  endfunction

  assign ctl_q   = regs_q[IDX_CTL];
  assign rd_word = regs_q[sel_idx];
  assign wr_ctl  = wr_en && (sel_idx == SEL_W'(IDX_CTL));
  assign chg     = regs_q[IDX_CTL] ^ wdata;
  assign upd     = wr_en || (|core_done);

  // request decode: enables first (highest core down), then resets
  always_comb begin
    act = '0;
    for (int c = 0; c < NCORE; c++) begin
      act_kind[c]  = REQ_NONE;
      act_entry[c] = '0;
      act_arg[c]   = '0;
    end
    if (wr_ctl) begin
      for (int c = NCORE - 1; c >= 1; c--) begin
        if (chg[EN_BASE+c-1]) begin
          act[c]       = 1'b1;
          act_kind[c]  = wdata[EN_BASE+c-1] ? REQ_START : REQ_STOP;
          act_entry[c] = regs_q[IDX_GP_BASE + 2*c];
          act_arg[c]   = regs_q[IDX_GP_BASE + 2*c + 1];
        end
      end
      for (int c = 0; c < NCORE; c++) begin
        if (!act[c] && chg[RST_BASE+c]) begin
          act[c]      = 1'b1;
          act_kind[c] = REQ_RESET;
        end
      end
    end
  end

  // register next state
  always_comb begin
    for (int i = 0; i < NREG; i++) regs_d[i] = regs_q[i];
    pend_d = pend_q;
    if (wr_en) regs_d[sel_idx] = wdata;
    if (wr_ctl) begin
      if (chg[PERI_A]) regs_d[IDX_CTL][PERI_A] = 1'b0;
      if (chg[PERI_B]) regs_d[IDX_CTL][PERI_B] = 1'b0;
    end
    for (int c = 0; c < NCORE; c++) begin
      if (act[c]) begin
        pend_d[c] = 1'b1;
      end else if (core_done[c] && pend_q[c]) begin
        regs_d[IDX_CTL][RST_BASE+c] = 1'b0;
        pend_d[c] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs_q[i] <= reg_init(i);
      pend_q <= '0;
    end else if (upd) begin
      for (int i = 0; i < NREG; i++) regs_q[i] <= regs_d[i];
      pend_q <= pend_d;
    end
  end

  // R9: peripheral reset bits never stay set
  a_r9_peri_low: assert property (@(posedge clk) disable iff (!rst_n)
    !regs_q[IDX_CTL][PERI_A] && !regs_q[IDX_CTL][PERI_B]);

  for (genvar g = 0; g < NCORE; g++) begin : g_chk
    // R8: completion clears the pending reset bit
    a_r8_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
      pend_q[g] && core_done[g] && !act[g] |=> !regs_q[IDX_CTL][RST_BASE+g]);
    // R8: stray completion has no effect
    a_r8_stray_done: assert property (@(posedge clk) disable iff (!rst_n)
      !pend_q[g] && core_done[g] && !wr_en |=> $stable(regs_q[IDX_CTL][RST_BASE+g]));
  end

endmodule

// File: rtl/rst_ctl_chan.sv
module rst_ctl_chan
  import rst_ctl_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue,
  input  req_kind_e         kind_in,
  input  logic [DATA_W-1:0] entry_in,
  input  logic [DATA_W-1:0] arg_in,
  input  logic              ready,
  output logic              valid,
  output req_kind_e         kind,
  output logic [DATA_W-1:0] entry,
  output logic [DATA_W-1:0] arg
);
  logic              valid_d;
  logic              load;

  assign load = issue;

  always_comb begin
    valid_d = valid;
    if (issue)              valid_d = 1'b1;
    else if (valid && ready) valid_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
    end else begin
      valid <= valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind  <= REQ_NONE;
      entry <= '0;
      arg   <= '0;
    end else if (load) begin
      kind  <= kind_in;
      entry <= entry_in;
      arg   <= arg_in;
    end
  end

  // R7: request held while not accepted
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    valid && !ready && !issue |=> valid && $stable(kind) && $stable(entry) && $stable(arg));
  // R7: accepted request retires
  a_r7_retire: assert property (@(posedge clk) disable iff (!rst_n)
    valid && ready && !issue |=> !valid);

endmodule

// File: rtl/mcore_rst_ctl.sv
module mcore_rst_ctl
  import rst_ctl_pkg::*;
#(
  parameter int NCORE  = 4,
  parameter int NGP    = 10,
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bus_sel,
  input  logic                    bus_we,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic [DATA_W-1:0]       bus_wdata,
  output logic [DATA_W-1:0]       bus_rdata,
  output logic [NCORE-1:0]        core_req_valid,
  output logic [2*NCORE-1:0]      core_req_kind,
  output logic [DATA_W*NCORE-1:0] core_req_entry,
  output logic [DATA_W*NCORE-1:0] core_req_arg,
  input  logic [NCORE-1:0]        core_req_ready,
  input  logic [NCORE-1:0]        core_done
);
  localparam int NREG  = NFIXED + NGP;
  localparam int SEL_W = $clog2(NREG);

  logic [1:0]        rst_sync;
  logic              rst_ni;
  logic [SEL_W-1:0]  sel_idx;
  logic              wr_en;
  logic [DATA_W-1:0] rd_word;
  logic [DATA_W-1:0] ctl_q;
  logic [NCORE-1:0]  act;
  req_kind_e         act_kind  [NCORE];
  logic [DATA_W-1:0] act_entry [NCORE];
  logic [DATA_W-1:0] act_arg   [NCORE];
  req_kind_e         ch_kind   [NCORE];
  logic [DATA_W-1:0] ch_entry  [NCORE];
  logic [DATA_W-1:0] ch_arg    [NCORE];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ni = rst_sync[1];

  rst_ctl_bus #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NREG(NREG), .SEL_W(SEL_W)) u_bus (
    .clk(clk), .rst_n(rst_ni), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .rd_word(rd_word), .sel_idx(sel_idx),
    .wr_en(wr_en), .bus_rdata(bus_rdata)
  );

  rst_ctl_regs #(.NCORE(NCORE), .NGP(NGP), .DATA_W(DATA_W), .SEL_W(SEL_W)) u_regs (
    .clk(clk), .rst_n(rst_ni), .wr_en(wr_en), .sel_idx(sel_idx),
    .wdata(bus_wdata), .core_done(core_done), .rd_word(rd_word),
    .ctl_q(ctl_q), .act(act), .act_kind(act_kind),
    .act_entry(act_entry), .act_arg(act_arg)
  );

  for (genvar g = 0; g < NCORE; g++) begin : g_core
    rst_ctl_chan #(.DATA_W(DATA_W)) u_chan (
      .clk(clk), .rst_n(rst_ni), .issue(act[g]), .kind_in(act_kind[g]),
      .entry_in(act_entry[g]), .arg_in(act_arg[g]), .ready(core_req_ready[g]),
      .valid(core_req_valid[g]), .kind(ch_kind[g]),
      .entry(ch_entry[g]), .arg(ch_arg[g])
    );
    assign core_req_kind[2*g +: 2]            = ch_kind[g];
    assign core_req_entry[DATA_W*g +: DATA_W] = ch_entry[g];
    assign core_req_arg[DATA_W*g +: DATA_W]   = ch_arg[g];

    if (g == 0) begin : g_rst_only
      // R6: core 0 change of reset bit gives a reset request
      a_r6_core0_reset: assert property (@(posedge clk) disable iff (!rst_ni)
        wr_en && (sel_idx == SEL_W'(IDX_CTL)) && (bus_wdata[RST_BASE] != ctl_q[RST_BASE])
        |=> core_req_valid[0] && (core_req_kind[1:0] == 2'b11));
    end else begin : g_pwr
      // R5: enable rise starts the core
      a_r5_start_on_rise: assert property (@(posedge clk) disable iff (!rst_ni)
        wr_en && (sel_idx == SEL_W'(IDX_CTL)) && bus_wdata[EN_BASE+g-1] && !ctl_q[EN_BASE+g-1]
        |=> core_req_valid[g] && (core_req_kind[2*g +: 2] == 2'b01));
      // R5: enable fall stops the core
      a_r5_stop_on_fall: assert property (@(posedge clk) disable iff (!rst_ni)
        wr_en && (sel_idx == SEL_W'(IDX_CTL)) && !bus_wdata[EN_BASE+g-1] && ctl_q[EN_BASE+g-1]
        |=> core_req_valid[g] && (core_req_kind[2*g +: 2] == 2'b10));
    end
  end

endmodule

// File: tb/tb_mcore_rst_ctl.sv
module tb_mcore_rst_ctl;
  localparam int CLK_PERIOD = 10;
  localparam int NCORE = 4;
  localparam int NREG  = 16;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_we;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [3:0]  core_req_valid;
  logic [7:0]  core_req_kind;
  logic [127:0] core_req_entry, core_req_arg;
  logic [3:0]  core_req_ready, core_done;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [31:0] exp_regs [NREG];
  logic [3:0]  pend;
  logic [3:0]  ev;
  logic [1:0]  ek [NCORE];
  logic [31:0] ee [NCORE];
  logic [31:0] ea [NCORE];

  mcore_rst_ctl dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .core_req_valid(core_req_valid), .core_req_kind(core_req_kind),
    .core_req_entry(core_req_entry), .core_req_arg(core_req_arg),
    .core_req_ready(core_req_ready), .core_done(core_done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(input logic [11:0] a);
    if (a[1:0] != 2'b00 || a[11:2] >= 10'd16) return 32'h0;
    return exp_regs[a[5:2]];
  endfunction

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [11:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    v = bus_rdata;
  endtask

  task automatic read_check(input logic [11:0] a, input string tag);
    logic [31:0] v;
    bus_read(a, v);
    check(v == exp_read(a), tag, v, exp_read(a));
  endtask

  // model of a control write (R4, R5, R6, R9, R10)
  task automatic model_ctl(input logic [31:0] w);
    logic [31:0] chg;
    logic [31:0] nv;
    chg = exp_regs[0] ^ w;
    nv  = w;
    for (int c = NCORE - 1; c >= 0; c--) begin
      if (c > 0 && chg[21+c]) begin
        ev[c] = 1'b1; ek[c] = w[21+c] ? 2'b01 : 2'b10;
        ee[c] = exp_regs[6+2*c]; ea[c] = exp_regs[7+2*c]; pend[c] = 1'b1;
      end else if (chg[13+c]) begin
        ev[c] = 1'b1; ek[c] = 2'b11; pend[c] = 1'b1;
      end
    end
    nv[3] = 1'b0; nv[12] = 1'b0;
    exp_regs[0] = nv;
  endtask

  task automatic ctl_write(input logic [31:0] w);
    model_ctl(w);
    bus_write(12'h000, w);
  endtask

  task automatic plain_write(input logic [11:0] a, input logic [31:0] d);
    if (a[1:0] == 2'b00 && a[11:2] < 10'd16 && a[11:2] != 10'd0) exp_regs[a[5:2]] = d;
    bus_write(a, d);
  endtask

  task automatic check_chans(input string tag);
    for (int c = 0; c < NCORE; c++) begin
      check(core_req_valid[c] == ev[c], {tag, " valid"}, 32'(core_req_valid[c]), 32'(ev[c]));
      if (ev[c]) begin
        check(core_req_kind[2*c +: 2] == ek[c], {tag, " kind"}, 32'(core_req_kind[2*c +: 2]), 32'(ek[c]));
        if (ek[c] == 2'b01) begin
          check(core_req_entry[32*c +: 32] == ee[c], {tag, " entry"}, core_req_entry[32*c +: 32], ee[c]);
          check(core_req_arg[32*c +: 32] == ea[c], {tag, " arg"}, core_req_arg[32*c +: 32], ea[c]);
        end
      end
    end
  endtask

  task automatic accept_all();
    @(negedge clk);
    core_req_ready = 4'hF;
    @(negedge clk);
    core_req_ready = 4'h0;
    ev = '0;
    check(core_req_valid == 4'h0, "R7 retire after accept", 32'(core_req_valid), 32'h0);
  endtask

  task automatic pulse_done(input logic [3:0] m);
    @(negedge clk);
    core_done = m;
    @(negedge clk);
    core_done = 4'h0;
    for (int c = 0; c < NCORE; c++) begin
      if (m[c] && pend[c]) begin
        exp_regs[0][13+c] = 1'b0;
        pend[c] = 1'b0;
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; bus_sel = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    core_req_ready = '0; core_done = '0;
    for (int i = 0; i < NREG; i++) exp_regs[i] = 32'h0;
    exp_regs[0] = 32'h521; exp_regs[2] = 32'h1; exp_regs[4] = 32'h1F;
    pend = '0; ev = '0;
    for (int c = 0; c < NCORE; c++) begin ek[c] = 2'b00; ee[c] = '0; ea[c] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check(core_req_valid == 4'h0, "R1 no request after reset", 32'(core_req_valid), 32'h0);
    for (int i = 0; i < NREG; i++) read_check(12'(i*4), "R1 reset value");
    read_check(12'h040, "R3 index 16 reads zero");

    // R2 plain storage and GP pairs
    for (int i = 1; i < NREG; i++) plain_write(12'(i*4), 32'hA500_0000 | 32'(i*32'h111));
    for (int i = 1; i < NREG; i++) read_check(12'(i*4), "R2 readback");

    // R3 misaligned and out of range
    plain_write(12'h019, 32'hDEAD_BEEF);
    read_check(12'h018, "R3 misaligned write ignored");
    read_check(12'h01A, "R3 misaligned read zero");
    plain_write(12'h050, 32'h1234_5678);
    read_check(12'h050, "R3 out of range write ignored");
    read_check(12'hFFC, "R3 top of window reads zero");

    // R5 start core 1, R7 hold without ready
    ctl_write(exp_regs[0] | (32'h1 << 22));
    check_chans("R5 start core1");
    @(negedge clk);
    check_chans("R7 hold while not ready");
    accept_all();

    // R6 reset core 2, R8 stray done then real done
    ctl_write(exp_regs[0] | (32'h1 << 15));
    check_chans("R6 reset core2");
    accept_all();
    pulse_done(4'b1000);
    read_check(12'h000, "R8 stray done on core3 ignored");
    pulse_done(4'b0100);
    read_check(12'h000, "R8 done clears core2 reset bit");

    // R4 same value write
    ctl_write(exp_regs[0]);
    check_chans("R4 unchanged write no request");

    // R6 masking: enable and reset of core 2 in one write
    ctl_write(exp_regs[0] | (32'h1 << 23) | (32'h1 << 15));
    check_chans("R6 enable masks reset core2");
    accept_all();
    pulse_done(4'b0110);
    read_check(12'h000, "R8 done after start");

    // R5 stop core 1
    ctl_write(exp_regs[0] & ~(32'h1 << 22));
    check_chans("R5 stop core1");
    accept_all();

    // R9 peripheral bits, R10 other bits stored
    ctl_write(exp_regs[0] | 32'h0000_1008 | 32'h8000_0040);
    read_check(12'h000, "R9 R10 peripheral low other bits stored");
    check_chans("R10 no core request");

    // R10 all cores in one write
    ctl_write(exp_regs[0] ^ ((32'h7 << 22) | (32'h1 << 13)));
    check_chans("R10 independent per-core requests");
    accept_all();
    pulse_done(4'hF);
    read_check(12'h000, "R8 all done");

    // random phase
    for (int it = 0; it < 400; it++) begin
      int op;
      op = int'($urandom % 4);
      case (op)
        0: plain_write(12'((1 + $urandom % 15) * 4), $urandom);
        1: begin
          logic [31:0] m;
          m = $urandom & ((($urandom % 4) == 0) ? 32'hFFFF_FFFF : 32'h01C1_F008);
          ctl_write(exp_regs[0] ^ m);
          check_chans("R5 R6 random control write");
          if ($urandom % 2 == 0) begin
            @(negedge clk);
            check_chans("R7 random hold");
          end
          accept_all();
          pulse_done(4'($urandom));
          read_check(12'h000, "R8 random done");
        end
        2: read_check(12'(($urandom % 24) * 4), "R2 random read");
        default: plain_write(12'($urandom), $urandom);
      endcase
    end
    for (int i = 0; i < NREG; i++) read_check(12'(i*4), "R2 final sweep");

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule